// File: doc/BRIEF.md
# Serial Memory Status Register Engine

This block is the slave-side status register logic of a serial memory reached over a four-wire serial link. It recognises two one-byte commands, a status read and a status write, and owns the 8-bit status register. A status read streams the register onto the serial output, most significant bit first, and keeps repeating the byte for as long as select stays low and the serial clock keeps running. A status write takes one data byte and updates the writable bits. The write-enable bit is never taken from the data, and bit 0 is hardwired to zero. A separate command decoder sets and clears the write-enable bit through two pulse inputs. The current register value is always visible on a parallel output.

All serial pins are sampled in a system clock domain. The serial clock and select are treated as slow, synchronous data signals, and their edges are found by comparing each sample with the one before. The link uses mode 0: SI is captured on the serial clock's rising edge, and SO changes on its falling edge. A write only commits on the clock edge that sees select rise. The write must also have been allowed when its opcode completed, which means write-enable was set and the protect rule did not block it. Finally, exactly 16 serial clocks must have been received.

Top module: `ssr_engine`

## Requirements
- R1: The opcode is the first 8 SI bits after select falls, sampled on rising serial clock edges, most significant bit first. 8'h05 is a status read and 8'h01 is a status write. Any other value is ignored.
- R2: After a read opcode, the falling serial clock edge that ends the 8th clock drives status bit 7 onto `so`. Each later falling edge drives the next lower bit, and `so_oe` is high during this data phase.
- R3: While select stays low during a read, each further group of 8 serial clocks sends the status byte again, starting from bit 7.
- R4: SI values shifted in during the read data phase change no status bit.
- R5: `so_oe` is low whenever `cs_n` is high, while the opcode is being received, throughout a write command, and after an unrecognised opcode.
- R6: A write commits only when three conditions hold. Write-enable (status bit 1) was 1 when the opcode completed. Exactly 16 rising serial clock edges were received. Select then rises. On commit, status bits 7..2 take data bits 7..2 (data sent most significant bit first) and write-enable becomes 0.
- R7: Data bits 1 and 0 of a write are ignored. Status bit 1 changes only through `wel_set`, `wel_clr` or a committed write, and status bit 0 always reads 0.
- R8: A write is discarded, and the status register left unchanged, if write-enable was 0 when the opcode completed or if the clock count is not exactly 16.
- R9: Status bit 7 enables protection. If it is 1 and `wp_n` is low when the write opcode completes, the write is discarded and write-enable stays as it was.
- R10: An unrecognised opcode changes no status bit until select rises.
- R11: After reset, `status` is 8'h00 and `so_oe` is 0. A `wel_set` pulse sets bit 1, and a `wel_clr` pulse clears it. Both take effect one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | One-cycle pulse that sets write-enable |
| wel_clr | input | 1 | One-cycle pulse that clears write-enable |
| so | output | 1 | Serial data out, valid while `so_oe` is high |
| so_oe | output | 1 | Output driver enable for `so` |
| status | output | 8 | Current status register value |

## Verification
Every serial clock or select edge acts on the first system clock edge after the pin changes. A data bit, a decoded opcode, a new `so` bit and a committed write therefore all appear one clock after the serial event that causes them. `so_oe` falls in the same cycle that `cs_n` rises, and the `wel_set` and `wel_clr` pulses show on `status` one clock later. The bench holds each serial clock level for four system clocks and samples outputs on the falling system clock edge at the end of that window, well after the one-clock latency. The status model is updated only when the bench's own commit rule (enable, protect, exact count) says so. It is then compared against both the parallel port and the bits read back serially.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    // Width of one serial byte: opcodes, data and the status register.
    localparam int BYTE_W = 8;

    // Command opcodes.
    localparam logic [BYTE_W-1:0] OP_READ_STAT  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRITE_STAT = 8'h01;

    // Status bit roles.
    localparam int WEN_BIT  = 1;
    localparam int PROT_BIT = BYTE_W - 1;

    // Bits a status write may change: all but write-enable and bit 0.
    localparam logic [BYTE_W-1:0] WR_MASK = {{(BYTE_W-2){1'b1}}, 2'b00};

    // Command phase after the opcode byte.
    typedef enum logic [1:0] {
        PH_OPCODE = 2'd0,
        PH_READ   = 2'd1,
        PH_WRITE  = 2'd2,
        PH_IGNORE = 2'd3
    } phase_t;

endpackage

// File: rtl/ssr_edge_detect.sv
// ssr_edge_detect
// Finds the edges of the serial clock and of chip select by comparing each
// pin with its value one system clock earlier.
// Assumes: sck and cs_n are already synchronous to clk, and each level lasts
// at least one clk period.
module ssr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);

    logic sck_q;
    logic cs_q;

    // Keep the previous sample of each pin; reset values match the idle bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Flag an edge whenever the current sample differs from the stored one.
    always_comb begin
        sck_rise = sck & ~sck_q;
        sck_fall = ~sck & sck_q;
        cs_rise  = cs_n & ~cs_q;
    end

endmodule

// File: rtl/ssr_cmd_seq.sv
// ssr_cmd_seq
// Shifts in SI on rising serial clock edges and counts serial clocks. After
// the 8th clock it decodes the opcode into a command phase. For a write it
// records whether the command may commit (write-enable set, not protected).
// On the select rising edge it issues a commit pulse if exactly two bytes
// were clocked.
// Assumes: select high returns everything to the opcode phase.
module ssr_cmd_seq
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              cs_rise,
    input  logic              si,
    input  logic              wen,
    input  logic              prot_en,
    input  logic              wp_n,
    output phase_t            phase,
    output logic              wr_commit,
    output logic [BYTE_W-1:0] wr_data
);

    localparam int FRAME_CLKS = 2 * BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_CLKS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FRAME_N  = CNT_W'(FRAME_CLKS);

    logic [CNT_W-1:0]  clk_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nxt;
    logic              armed;
    phase_t            phase_q;

    // Next content of the shift register if this cycle takes a bit.
    always_comb begin
        shreg_nxt = {shreg[BYTE_W-2:0], si};
    end

    // Count clocks, shift SI, decode the opcode and latch the write permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_cnt <= '0;
            shreg   <= '0;
            armed   <= 1'b0;
            phase_q <= PH_OPCODE;
        end else if (cs_n) begin
            clk_cnt <= '0;
            shreg   <= '0;
            armed   <= 1'b0;
            phase_q <= PH_OPCODE;
        end else if (sck_rise) begin
            shreg <= shreg_nxt;
            if (clk_cnt != CNT_MAX) begin
                clk_cnt <= clk_cnt + 1'b1;
            end
            if (phase_q == PH_OPCODE && clk_cnt == OPC_LAST) begin
                if (shreg_nxt == OP_READ_STAT) begin
                    phase_q <= PH_READ;
                end else if (shreg_nxt == OP_WRITE_STAT) begin
                    phase_q <= PH_WRITE;
                    armed   <= wen & ~(prot_en & ~wp_n);
                end else begin
                    phase_q <= PH_IGNORE;
                end
            end
        end
    end

    // A commit needs a permitted write and exactly one opcode and one data byte.
    always_comb begin
        wr_commit = cs_rise && (phase_q == PH_WRITE) && armed && (clk_cnt == FRAME_N);
        wr_data   = shreg;
        phase     = phase_q;
    end

    // R1: the phase leaves opcode only on the rising edge that ends the 8th clock.
    p_decode_at_eighth_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_OPCODE && $past(phase_q) == PH_OPCODE)
            |-> ($past(clk_cnt) == OPC_LAST && $past(sck_rise)));

    // R5: a deselected device is back in the opcode phase on the next clock.
    p_deselect_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase_q == PH_OPCODE && clk_cnt == '0));

endmodule

// File: rtl/ssr_status_reg.sv
// ssr_status_reg
// Holds the status byte. A committed write loads the writable bits and
// clears write-enable. The external set and clear pulses control
// write-enable only, and bit 0 is forced to zero.
// Assumes: wr_commit is a single-cycle pulse, and wel_clr wins over wel_set.
module ssr_status_reg
    import ssr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wel_set,
    input  logic              wel_clr,
    output logic [BYTE_W-1:0] status
);

    logic [BYTE_W-1:0] st_q;
    logic [BYTE_W-1:0] st_nxt;

    // Work out each bit's next value from its role.
    always_comb begin
        for (int i = 0; i < BYTE_W; i++) begin
            if (i == 0) begin
                st_nxt[i] = 1'b0;
            end else if (i == WEN_BIT) begin
                if (wr_commit || wel_clr) begin
                    st_nxt[i] = 1'b0;
                end else if (wel_set) begin
                    st_nxt[i] = 1'b1;
                end else begin
                    st_nxt[i] = st_q[i];
                end
            end else begin
                st_nxt[i] = (wr_commit && WR_MASK[i]) ? wr_data[i] : st_q[i];
            end
        end
    end

    // Register the status byte; bit 0 is cleared even in the reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_VAL & ~BYTE_W'(1);
        end else begin
            st_q <= st_nxt;
        end
    end

    assign status = st_q;

    // R7: bit 0 always reads zero.
    p_bit0_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[0] == 1'b0);

    // R6: write-enable is clear the cycle after a commit.
    p_wen_drops_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !st_q[WEN_BIT]);

    // R4: without a commit the writable bits hold.
    p_hold_without_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(st_q[BYTE_W-1:2]));

    // R7: write-enable moves only through the pulses or a commit.
    p_wen_only_by_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_commit && !wel_set && !wel_clr) |=> $stable(st_q[WEN_BIT]));

endmodule

// File: rtl/ssr_so_drive.sv
// ssr_so_drive
// Streams the status byte onto SO during a read, one bit per falling serial
// clock edge, MSB first. The bit index wraps so the byte repeats. The
// driver is enabled from the first falling edge of the data phase until
// select rises.
// Assumes: in_read is high from the rising edge that ends the opcode.
module ssr_so_drive
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_fall,
    input  logic              in_read,
    input  logic [BYTE_W-1:0] status,
    output logic              so,
    output logic              so_oe
);

    localparam int IDX_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

    logic [IDX_W-1:0] idx;
    logic             so_q;
    logic             oe_q;

    // Step through the status bits on each falling edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            so_q <= 1'b0;
            oe_q <= 1'b0;
        end else if (cs_n) begin
            idx  <= '0;
            oe_q <= 1'b0;
        end else if (in_read && sck_fall) begin
            so_q <= status[IDX_LAST - idx];
            idx  <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
            oe_q <= 1'b1;
        end
    end

    // Gate the enable with select so the driver releases at once.
    always_comb begin
        so    = so_q;
        so_oe = oe_q & ~cs_n;
    end

    // R2: SO changes only on a falling serial clock edge.
    p_so_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_q));

    // R5: the driver is on only during a read.
    p_oe_only_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> in_read);

endmodule

// File: rtl/ssr_engine.sv
// ssr_engine
// Top of the status register engine. It wires the edge detector, the command
// sequencer, the status register and the SO driver together.
// Assumes: mode 0 serial timing, serial pins synchronous to clk, and wp_n
// stable for the whole of a write command.
module ssr_engine
    import ssr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              wp_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    output logic              so,
    output logic              so_oe,
    output logic [BYTE_W-1:0] status
);

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_rise;
    phase_t            phase;
    logic              wr_commit;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] st;

    ssr_edge_detect edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    ssr_cmd_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck_rise  (sck_rise),
        .cs_rise   (cs_rise),
        .si        (si),
        .wen       (st[WEN_BIT]),
        .prot_en   (st[PROT_BIT]),
        .wp_n      (wp_n),
        .phase     (phase),
        .wr_commit (wr_commit),
        .wr_data   (wr_data)
    );

    ssr_status_reg #(
        .RESET_VAL (RESET_VAL)
    ) sreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .wr_data   (wr_data),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .status    (st)
    );

    ssr_so_drive drv_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck_fall (sck_fall),
        .in_read  (phase == PH_READ),
        .status   (st),
        .so       (so),
        .so_oe    (so_oe)
    );

    assign status = st;

    // R5: no output drive while deselected.
    p_oe_off_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);

    // R10: an ignored command never commits a write.
    p_ignore_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> !wr_commit);

endmodule

// File: tb/ssr_engine_tb.sv
module ssr_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    logic       wel_set = 1'b0;
    logic       wel_clr = 1'b0;
    logic       so;
    logic       so_oe;
    logic [7:0] status;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [7:0] exp_st = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ssr_engine dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .si      (si),
        .wp_n    (wp_n),
        .wel_set (wel_set),
        .wel_clr (wel_clr),
        .so      (so),
        .so_oe   (so_oe),
        .status  (status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sck_pulse(input logic b);
        si  = b;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
        tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) sck_pulse(b[i]);
    endtask

    task automatic select_dev();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic deselect_dev();
        cs_n = 1'b1;
        tick(HALF);
        check("R5 oe off when deselected", {7'd0, so_oe}, 8'h00);
    endtask

    task automatic pulse_set();
        wel_set = 1'b1;
        tick(1);
        wel_set = 1'b0;
        exp_st[1] = 1'b1;
        check("R11 wel_set", status, exp_st);
    endtask

    task automatic pulse_clr();
        wel_clr = 1'b1;
        tick(1);
        wel_clr = 1'b0;
        exp_st[1] = 1'b0;
        check("R11 wel_clr", status, exp_st);
    endtask

    // Write command with nclk total serial clocks (opcode included).
    task automatic do_write(input logic [7:0] d, input int nclk, input string tag);
        bit ok;
        ok = exp_st[1] && !(exp_st[7] && !wp_n) && (nclk == 16);
        select_dev();
        send_byte(8'h01);
        check("R5 oe off after write opcode", {7'd0, so_oe}, 8'h00);
        for (int i = 0; i < nclk - 8; i++) sck_pulse((i < 8) ? d[7 - i] : 1'b1);
        check("R5 oe off in write data", {7'd0, so_oe}, 8'h00);
        deselect_dev();
        if (ok) begin
            exp_st[7:2] = d[7:2];
            exp_st[1]   = 1'b0;
        end
        check(tag, status, exp_st);
    endtask

    // Status read of nbytes repeated bytes, checking each SO bit.
    task automatic do_read(input int nbytes);
        select_dev();
        for (int i = 7; i >= 0; i--) begin
            sck_pulse(i == 2 || i == 0);
            if (i == 4) check("R5 oe off during opcode", {7'd0, so_oe}, 8'h00);
        end
        for (int k = 0; k < nbytes; k++) begin
            for (int i = 0; i < 8; i++) begin
                check((k == 0) ? "R2 read bit" : "R3 repeated bit", {6'd0, so_oe, so},
                      {6'd0, 1'b1, exp_st[7 - i]});
                sck_pulse(logic'((i + k) % 2));
            end
        end
        deselect_dev();
        check("R4 SI ignored in read", status, exp_st);
    endtask

    // Unknown opcode followed by a byte of ones.
    task automatic do_unknown(input logic [7:0] op);
        select_dev();
        send_byte(op);
        send_byte(8'hFF);
        check("R10 unknown opcode oe", {7'd0, so_oe}, 8'h00);
        check("R10 unknown opcode status", status, exp_st);
        deselect_dev();
        check("R10 status after unknown", status, exp_st);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R11 reset status", status, 8'h00);
        check("R11 reset oe", {7'd0, so_oe}, 8'h00);

        // R6/R7/R2 sweep: every data value written then read back.
        for (int d = 0; d < 256; d++) begin
            pulse_set();
            do_write(8'(d), 16, "R6 R7 write sweep");
            do_read(1);
        end

        // R3: three repeated bytes with a mixed pattern.
        pulse_set();
        do_write(8'hB4, 16, "R6 write B4");
        pulse_set();
        do_read(3);

        // R8: write-enable clear, then wrong clock counts.
        pulse_clr();
        do_write(8'h58, 16, "R8 write without enable");
        pulse_set();
        do_write(8'h58, 15, "R8 fifteen clocks");
        do_write(8'h58, 17, "R8 seventeen clocks");
        do_write(8'h58, 16, "R6 exact sixteen clocks");

        // R9: protection with wp_n low blocks, wp_n high allows.
        pulse_set();
        do_write(8'h84, 16, "R6 set protect bit");
        wp_n = 1'b0;
        pulse_set();
        do_write(8'h3C, 16, "R9 protected write ignored");
        check("R9 wel kept", {7'd0, status[1]}, 8'h01);
        wp_n = 1'b1;
        do_write(8'h3C, 16, "R9 unprotected write");

        // R1/R10: near-miss and unknown opcodes do nothing.
        pulse_set();
        do_unknown(8'h04);
        do_unknown(8'h85);
        do_unknown(8'h81);
        check("R1 wel after unknown", {7'd0, status[1]}, 8'h01);
        pulse_clr();
        do_read(1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual %0d expected %0d", WATCHDOG, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule